// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a small bank of hardware semaphore latches shared by a left port and a right port. Software on either side uses them to take turns over a shared resource. Each port has four inputs: a select strobe, a direction line, a semaphore index and a single data bit. It has one registered read-back bit. A port asks for a semaphore by writing 0 to it and gives it up by writing 1. When both sides want the same semaphore, only one of them holds it. The other side's request is kept waiting and is honoured automatically once the holder lets go.

Each semaphore is its own five-state machine, described below.

States:
- `SEM_FREE`: nobody holds the semaphore.
- `SEM_LEFT`: the left port holds it.
- `SEM_RIGHT`: the right port holds it.
- `SEM_LEFT_RWAIT`: the left port holds it and the right port is waiting.
- `SEM_RIGHT_LWAIT`: the right port holds it and the left port is waiting.

Transitions:
- From `SEM_FREE`:
  - a left request goes to `SEM_LEFT`;
  - a right request goes to `SEM_RIGHT`;
  - requests from both ports in the same cycle go to `SEM_LEFT_RWAIT`.
- From `SEM_LEFT`:
  - a left release goes to `SEM_FREE`, or to `SEM_RIGHT` if a right request arrives in the same cycle;
  - a right request alone goes to `SEM_LEFT_RWAIT`.
- From `SEM_LEFT_RWAIT`:
  - a left release hands the semaphore over to `SEM_RIGHT`;
  - a right release withdraws the waiting request and goes back to `SEM_LEFT`;
  - releases from both ports go to `SEM_FREE`.
- The right-hand states mirror the left-hand ones with the roles of the two ports swapped.

Top module: `two_port_sem`

## Requirements
- R1: There are eight semaphores, picked by the 3-bit index while the select strobe is high. An operation on one index never changes the state of any other index.
- R2: A write has the direction line at 1; a read has it at 0. Writing data bit 0 to a free semaphore makes the writing port its holder.
- R3: While one port holds a semaphore, a 0 written by the other port does not take it. The holder keeps it until the holder writes 1.
- R4: When the holder writes 1 and the other port has a waiting request, the other port becomes holder in that same update. It needs no further write.
- R5: A read returns 0 on the port's read bit when that port holds the selected semaphore, and 1 otherwise. The bit is registered: it is valid after the clock edge that samples the read, and it holds until the next read on that port.
- R6: When both ports write 0 to a free semaphore in the same cycle, the left port becomes the holder and the right port's request waits.
- R7: A port that writes 1 to a semaphore it does not hold only withdraws its own waiting request. The holder is unaffected.
- R8: After reset all semaphores are free with no waiting request, and both read bits are 1.
- R9: A holder that writes 1 with no request waiting leaves the semaphore free, so a later 0 from either port takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_sel | input | 1 | Left port semaphore select strobe |
| lt_wr | input | 1 | Left direction line: 1 for write, 0 for read |
| lt_idx | input | 3 | Left semaphore index |
| lt_wbit | input | 1 | Left write data: 0 requests, 1 releases |
| lt_rbit | output | 1 | Left read result: 0 when the left port holds the semaphore |
| rt_sel | input | 1 | Right port semaphore select strobe |
| rt_wr | input | 1 | Right direction line: 1 for write, 0 for read |
| rt_idx | input | 3 | Right semaphore index |
| rt_wbit | input | 1 | Right write data: 0 requests, 1 releases |
| rt_rbit | output | 1 | Right read result: 0 when the right port holds the semaphore |

## Verification
A write changes the semaphore state at the clock edge that samples it, so a read presented in any later cycle already sees the new holder. The read bit is registered once more and is valid after the edge that samples the read.

The bench drives every operation on the falling edge and holds it for one full cycle. It samples the read bit at the next falling edge, which falls after the one rising edge that captures it. A handover on release is therefore checked by the very next read from the waiting port, with no write from that port in between.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [2:0] {
        SEM_FREE,
        SEM_LEFT,
        SEM_RIGHT,
        SEM_LEFT_RWAIT,
        SEM_RIGHT_LWAIT
    } sem_state_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wbit,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel
);
    always_comb begin
        for (int i = 0; i < NUM_SEM; i++) begin
            req[i] = sel && wr && !wbit && (idx == IDX_W'(i));
            rel[i] = sel && wr &&  wbit && (idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_own,
    output logic r_own
);
    sem_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (l_req && r_req) state_d = SEM_LEFT_RWAIT;
                else if (l_req)     state_d = SEM_LEFT;
                else if (r_req)     state_d = SEM_RIGHT;
            end
            SEM_LEFT: begin
                if (l_rel)      state_d = r_req ? SEM_RIGHT : SEM_FREE;
                else if (r_req) state_d = SEM_LEFT_RWAIT;
            end
            SEM_RIGHT: begin
                if (r_rel)      state_d = l_req ? SEM_LEFT : SEM_FREE;
                else if (l_req) state_d = SEM_RIGHT_LWAIT;
            end
            SEM_LEFT_RWAIT: begin
                if (l_rel && r_rel) state_d = SEM_FREE;
                else if (l_rel)     state_d = SEM_RIGHT;
                else if (r_rel)     state_d = SEM_LEFT;
            end
            SEM_RIGHT_LWAIT: begin
                if (l_rel && r_rel) state_d = SEM_FREE;
                else if (r_rel)     state_d = SEM_LEFT;
                else if (l_rel)     state_d = SEM_RIGHT;
            end
            default: state_d = SEM_FREE;
        endcase
    end

    always_comb begin
        l_own = (state_q == SEM_LEFT)  || (state_q == SEM_LEFT_RWAIT);
        r_own = (state_q == SEM_RIGHT) || (state_q == SEM_RIGHT_LWAIT);
    end

    // R3: holder keeps the semaphore while it does not release
    p_hold_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own && !l_rel) |=> l_own);

    // R4: waiting right request is granted on left release
    p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_LEFT_RWAIT && l_rel && !r_rel) |=> r_own);

    // R6: simultaneous requests on a free semaphore favour the left port
    p_tie_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && l_req && r_req) |=> (l_own && state_q == SEM_LEFT_RWAIT));

    // R7: withdrawing a waiting request leaves the holder in place
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_RIGHT_LWAIT && l_rel && !r_rel) |=> (state_q == SEM_RIGHT));

    // R9: release with nobody waiting frees the semaphore
    p_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_LEFT && l_rel && !r_req) |=> (!l_own && !r_own));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
    parameter int NUM_SEM = 8,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] own,
    output logic               rbit
);
    always_ff @(posedge clk) begin
        if (!rst_n)          rbit <= 1'b1;
        else if (sel && !wr) rbit <= !own[idx];
    end

    // R5: read bit holds between reads
    p_rbit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr) |=> $stable(rbit));
endmodule

// File: rtl/two_port_sem.sv
module two_port_sem #(
    parameter int NUM_SEM = 8,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lt_sel,
    input  logic             lt_wr,
    input  logic [IDX_W-1:0] lt_idx,
    input  logic             lt_wbit,
    output logic             lt_rbit,
    input  logic             rt_sel,
    input  logic             rt_wr,
    input  logic [IDX_W-1:0] rt_idx,
    input  logic             rt_wbit,
    output logic             rt_rbit
);
    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel, l_own, r_own;

    sem_port_decode #(.NUM_SEM(NUM_SEM)) u_dec_l (
        .sel(lt_sel), .wr(lt_wr), .idx(lt_idx), .wbit(lt_wbit),
        .req(l_req), .rel(l_rel)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM)) u_dec_r (
        .sel(rt_sel), .wr(rt_wr), .idx(rt_idx), .wbit(rt_wbit),
        .req(r_req), .rel(r_rel)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .l_own(l_own[g]), .r_own(r_own[g])
        );
    end

    sem_read_port #(.NUM_SEM(NUM_SEM)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .sel(lt_sel), .wr(lt_wr),
        .idx(lt_idx), .own(l_own), .rbit(lt_rbit)
    );

    sem_read_port #(.NUM_SEM(NUM_SEM)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .sel(rt_sel), .wr(rt_wr),
        .idx(rt_idx), .own(r_own), .rbit(rt_rbit)
    );

    // R3: the two ports never hold the same semaphore
    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own & r_own) == '0);

    // R1: untouched semaphores keep their holder
    p_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!lt_sel && !rt_sel) |=> ($stable(l_own) && $stable(r_own)));
endmodule

// File: tb/test_two_port_sem.sv
module test_two_port_sem;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lt_sel = 0, lt_wr = 0, lt_wbit = 0;
    logic rt_sel = 0, rt_wr = 0, rt_wbit = 0;
    logic [2:0] lt_idx = '0, rt_idx = '0;
    logic lt_rbit, rt_rbit;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    two_port_sem i_two_port_sem (
        .clk(clk), .rst_n(rst_n),
        .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_idx(lt_idx), .lt_wbit(lt_wbit), .lt_rbit(lt_rbit),
        .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_idx(rt_idx), .rt_wbit(rt_wbit), .rt_rbit(rt_rbit)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // one cycle of activity on either or both ports, then idle
    task automatic drive(input logic ls, input logic lw, input logic [2:0] li, input logic lb,
                         input logic rs, input logic rw, input logic [2:0] ri, input logic rb);
        @(negedge clk);
        lt_sel = ls; lt_wr = lw; lt_idx = li; lt_wbit = lb;
        rt_sel = rs; rt_wr = rw; rt_idx = ri; rt_wbit = rb;
        @(negedge clk);
        lt_sel = 0; rt_sel = 0;
    endtask

    task automatic lwrite(input logic [2:0] i, input logic b); drive(1,1,i,b, 0,0,0,0); endtask
    task automatic rwrite(input logic [2:0] i, input logic b); drive(0,0,0,0, 1,1,i,b); endtask

    task automatic lread(input logic [2:0] i, input logic exp, input string req);
        drive(1,0,i,0, 0,0,0,0);
        check(lt_rbit, exp, req);
    endtask

    task automatic rread(input logic [2:0] i, input logic exp, input string req);
        drive(0,0,0,0, 1,0,i,0);
        check(rt_rbit, exp, req);
    endtask

    task automatic t_reset();
        check(lt_rbit, 1'b1, "R8 left rbit");
        check(rt_rbit, 1'b1, "R8 right rbit");
        for (int i = 0; i < 8; i++) lread(3'(i), 1'b1, "R8 free after reset");
    endtask

    task automatic t_basic();
        lwrite(3'd2, 1'b0);
        lread(3'd2, 1'b0, "R2 left holds");
        rread(3'd2, 1'b1, "R5 right not holder");
        lread(3'd3, 1'b1, "R1 neighbour untouched");
    endtask

    task automatic t_contend();
        rwrite(3'd2, 1'b0);
        rread(3'd2, 1'b1, "R3 right waits");
        lread(3'd2, 1'b0, "R3 left keeps");
        lwrite(3'd2, 1'b1);
        rread(3'd2, 1'b0, "R4 right granted");
        lread(3'd2, 1'b1, "R4 left released");
        rwrite(3'd2, 1'b1);
        rread(3'd2, 1'b1, "R9 right released");
        lwrite(3'd2, 1'b0);
        lread(3'd2, 1'b0, "R9 free retaken");
        lwrite(3'd2, 1'b1);
    endtask

    task automatic t_tie();
        drive(1,1,3'd5,0, 1,1,3'd5,0);
        lread(3'd5, 1'b0, "R6 left wins tie");
        rread(3'd5, 1'b1, "R6 right waits");
        lwrite(3'd5, 1'b1);
        rread(3'd5, 1'b0, "R6 right granted later");
        rwrite(3'd5, 1'b1);
    endtask

    task automatic t_cancel();
        lwrite(3'd7, 1'b0);
        rwrite(3'd7, 1'b0);
        rwrite(3'd7, 1'b1);
        lread(3'd7, 1'b0, "R7 holder unaffected");
        lwrite(3'd7, 1'b1);
        rread(3'd7, 1'b1, "R7 withdrawn not granted");
        lread(3'd7, 1'b1, "R7 free after release");
        rwrite(3'd4, 1'b0);
        lwrite(3'd4, 1'b1);
        rread(3'd4, 1'b0, "R7 non-holder release ignored");
        rwrite(3'd4, 1'b1);
    endtask

    task automatic t_indep();
        lwrite(3'd0, 1'b0);
        rwrite(3'd1, 1'b0);
        lread(3'd0, 1'b0, "R1 left idx0");
        rread(3'd1, 1'b0, "R1 right idx1");
        lread(3'd1, 1'b1, "R1 left idx1");
        rread(3'd0, 1'b1, "R1 right idx0");
        lwrite(3'd0, 1'b1);
        rread(3'd1, 1'b0, "R1 idx1 kept");
        rwrite(3'd1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_contend();
        t_tie();
        t_cancel();
        t_indep();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule